// File: doc/BRIEF.md
# Windowed Register File

This block presents 32 integer register specifiers to a pipeline and maps them onto a stack of register windows. A specifier selects one of four groups of eight: globals (0–7), outputs (8–15), locals (16–23) and inputs (24–31). Globals are shared by every window. The other three groups move with the window when the pipeline calls a procedure or returns from one. A save strobe opens a new window: the caller's outputs become the callee's inputs, the caller's inputs are pushed onto an on-chip frame stack, and the new locals and outputs read as zero. A restore strobe does the reverse: the inputs become outputs again, the locals clear, and the most recently pushed input frame returns as the inputs.

The on-chip frame stack holds `FRAMES` input frames. A save with every slot in use first spills the oldest frame to an external memory agent over a valid/ready stream. The spill stream carries one word per beat, and the word for specifier 24 goes first. A restore with no frame on chip but frames in memory pulls one frame back over a second valid/ready stream into the inputs. The agent returns frames last-in first-out. In both streams a beat moves only on a cycle where valid and ready are both high. The block holds `spill_valid` and `spill_data` steady while `spill_ready` is low. `fill_ready` stays high for the whole fill, and the agent may hold off with `fill_valid` low. `busy` is high while a spill or fill is in progress. Save, restore and write requests that arrive while `busy` is high are dropped, so the requester holds them until `busy` falls.

Top module: `windowed_regfile`

## Requirements
- R1: Specifier bits [4:3] select the group (0 global, 1 output, 2 local, 3 input) and bits [2:0] select the word within it. Globals keep their values across every save and restore.
- R2: Specifier 0 always reads zero, and a write to it changes nothing.
- R3: A read of a specifier in the same cycle as a write to it returns the old value. The new value is visible from the next cycle.
- R4: After an accepted save, inputs 24..31 read the values that outputs 8..15 held before it, and locals and outputs read zero.
- R5: After a restore served from the on-chip stack, outputs read the former inputs, locals read zero, and inputs read the frame that was last pushed.
- R6: Up to `FRAMES` nested saves from reset cause no spill traffic and never raise `busy`.
- R7: A save with `FRAMES` frames on chip raises `busy` and `spill_valid` from the next cycle. It sends the oldest frame as 8 beats, input word 0 first, and completes the save on the last accepted beat, after which `busy` is low.
- R8: A restore with no frame on chip and at least one frame in memory raises `busy` and `fill_ready`, moves the former inputs to outputs, clears locals, and writes 8 accepted fill beats into inputs 24..31 in order.
- R9: A restore with no saved frame anywhere pulses `underflow` for one cycle in the following cycle and leaves all visible registers unchanged.
- R10: While `busy` is high, save, restore and write requests have no effect. When save and restore are asserted together, save wins. A write in the same cycle as an accepted save or restore is dropped.
- R11: While `spill_valid` is high and `spill_ready` is low, `spill_valid` stays high and `spill_data` is stable in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| rd_a_idx | input | 5 | Read port A specifier |
| rd_a_data | output | XLEN | Read port A data |
| rd_b_idx | input | 5 | Read port B specifier |
| rd_b_data | output | XLEN | Read port B data |
| wr_en | input | 1 | Write strobe |
| wr_idx | input | 5 | Write specifier |
| wr_data | input | XLEN | Write data |
| save_req | input | 1 | Open a new window |
| restore_req | input | 1 | Close the current window |
| busy | output | 1 | Spill or fill in progress; requests dropped |
| underflow | output | 1 | One-cycle pulse: restore with nothing saved |
| spill_valid | output | 1 | Spill beat valid |
| spill_ready | input | 1 | Memory agent accepts a spill beat |
| spill_data | output | XLEN | Spill beat data |
| fill_valid | input | 1 | Fill beat valid |
| fill_ready | output | 1 | Block accepts a fill beat |
| fill_data | input | XLEN | Fill beat data |

## Verification
The bench builds the block with its defaults: 32-bit words, four on-chip frames and an 8-bit memory-depth counter. With four frames, six nested saves are enough to fill the stack and force two spills. Unwinding those saves takes four on-chip pops, two fills from the modelled agent and then one underflow. Every window transition, both streams under back-pressure and the error path are therefore reached in a few hundred cycles.

// File: rtl/wrf_pkg.sv
package wrf_pkg;
  localparam int GRP_SZ = 8;
  localparam int OFF_W  = $clog2(GRP_SZ);
  localparam int SPEC_W = 5;

  typedef enum logic [1:0] {
    GRP_GLB = 2'd0,
    GRP_OUT = 2'd1,
    GRP_LOC = 2'd2,
    GRP_IN  = 2'd3
  } wrf_grp_e;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_SPILL = 2'd1,
    ST_FILL  = 2'd2
  } wrf_state_e;
endpackage

// File: rtl/wrf_decode.sv
module wrf_decode
  import wrf_pkg::*;
(
  input  logic [SPEC_W-1:0] spec,
  input  logic              flip,
  output wrf_grp_e          grp,
  output logic [OFF_W-1:0]  off,
  output logic              bank,
  output logic              is_zero
);
  // outputs live in bank 'flip', inputs in the other bank
  assign grp     = wrf_grp_e'(spec[SPEC_W-1:OFF_W]);
  assign off     = spec[OFF_W-1:0];
  assign bank    = (grp == GRP_OUT) ? flip : ~flip;
  assign is_zero = (spec == '0);
endmodule

// File: rtl/wrf_frame_stack.sv
module wrf_frame_stack
  import wrf_pkg::*;
#(
  parameter int XLEN   = 32,
  parameter int FRAMES = 4,
  localparam int FPW   = (FRAMES > 1) ? $clog2(FRAMES) : 1,
  localparam int OCW   = $clog2(FRAMES + 1)
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic                              push_en,
  input  logic [GRP_SZ-1:0][XLEN-1:0]       push_frame,
  input  logic                              pop_en,
  input  logic                              drop_en,
  output logic [GRP_SZ-1:0][XLEN-1:0]       top_frame,
  input  logic [OFF_W-1:0]                  old_sel,
  output logic [XLEN-1:0]                   old_word,
  output logic [OCW-1:0]                    occ
);
  logic [XLEN-1:0] store [FRAMES][GRP_SZ];
  logic [FPW-1:0]  wp;
  logic [FPW-1:0]  wp_inc, wp_dec;

  assign wp_inc = (wp == FPW'(FRAMES - 1)) ? '0 : wp + 1'b1;
  assign wp_dec = (wp == '0) ? FPW'(FRAMES - 1) : wp - 1'b1;

  always_comb begin
    for (int i = 0; i < GRP_SZ; i++) top_frame[i] = store[wp_dec][i];
  end

  // the oldest frame sits at the write pointer whenever the stack is full
  assign old_word = store[wp][old_sel];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wp  <= '0;
      occ <= '0;
      for (int f = 0; f < FRAMES; f++)
        for (int i = 0; i < GRP_SZ; i++) store[f][i] <= '0;
    end else begin
      if (push_en) begin
        for (int i = 0; i < GRP_SZ; i++) store[wp][i] <= push_frame[i];
        wp <= wp_inc;
      end else if (pop_en) begin
        wp <= wp_dec;
      end
      occ <= occ + OCW'(push_en) - OCW'(pop_en) - OCW'(drop_en);
    end
  end
endmodule

// File: rtl/windowed_regfile.sv
module windowed_regfile
  import wrf_pkg::*;
#(
  parameter int XLEN      = 32,
  parameter int FRAMES    = 4,
  parameter int MEM_CNT_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [4:0]        rd_a_idx,
  output logic [XLEN-1:0]   rd_a_data,
  input  logic [4:0]        rd_b_idx,
  output logic [XLEN-1:0]   rd_b_data,
  input  logic              wr_en,
  input  logic [4:0]        wr_idx,
  input  logic [XLEN-1:0]   wr_data,
  input  logic              save_req,
  input  logic              restore_req,
  output logic              busy,
  output logic              underflow,
  output logic              spill_valid,
  input  logic              spill_ready,
  output logic [XLEN-1:0]   spill_data,
  input  logic              fill_valid,
  output logic              fill_ready,
  input  logic [XLEN-1:0]   fill_data
);
  localparam int OCW = $clog2(FRAMES + 1);

  logic [XLEN-1:0] glb [GRP_SZ];
  logic [XLEN-1:0] loc [GRP_SZ];
  logic [XLEN-1:0] bnk [2][GRP_SZ];
  logic            flip;
  wrf_state_e      state;
  logic [OFF_W-1:0] beat;
  logic [MEM_CNT_W-1:0] mem_cnt;

  logic [GRP_SZ-1:0][XLEN-1:0] in_frame, top_frame;
  logic [OCW-1:0] occ;
  logic full, empty, idle, last_beat;
  logic push_en, pop_en, drop_en;

  assign idle      = (state == ST_IDLE);
  assign full      = (occ == OCW'(FRAMES));
  assign empty     = (occ == '0);
  assign last_beat = (beat == OFF_W'(GRP_SZ - 1));
  assign drop_en   = (state == ST_SPILL) && spill_ready && last_beat;
  assign push_en   = (idle && save_req && !full) || drop_en;
  assign pop_en    = idle && !save_req && restore_req && !empty;

  always_comb begin
    for (int i = 0; i < GRP_SZ; i++) in_frame[i] = bnk[~flip][i];
  end

  wrf_frame_stack #(.XLEN(XLEN), .FRAMES(FRAMES)) u_stack (
    .clk(clk), .rst_n(rst_n),
    .push_en(push_en), .push_frame(in_frame),
    .pop_en(pop_en), .drop_en(drop_en),
    .top_frame(top_frame),
    .old_sel(beat), .old_word(spill_data),
    .occ(occ)
  );

  // read ports
  for (genvar p = 0; p < 2; p++) begin : g_rd
    wrf_grp_e         grp;
    logic [OFF_W-1:0] off;
    logic             bank, zero;
    logic [XLEN-1:0]  dat;
    wrf_decode u_dec (
      .spec((p == 0) ? rd_a_idx : rd_b_idx), .flip(flip),
      .grp(grp), .off(off), .bank(bank), .is_zero(zero)
    );
    always_comb begin
      if (zero) dat = '0;
      else begin
        case (grp)
          GRP_GLB: dat = glb[off];
          GRP_LOC: dat = loc[off];
          default: dat = bnk[bank][off];
        endcase
      end
    end
  end
  assign rd_a_data = g_rd[0].dat;
  assign rd_b_data = g_rd[1].dat;

  // write decode
  wrf_grp_e         w_grp;
  logic [OFF_W-1:0] w_off;
  logic             w_bank, w_zero;
  wrf_decode u_wdec (
    .spec(wr_idx), .flip(flip),
    .grp(w_grp), .off(w_off), .bank(w_bank), .is_zero(w_zero)
  );

  assign busy        = !idle;
  assign spill_valid = (state == ST_SPILL);
  assign fill_ready  = (state == ST_FILL);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state     <= ST_IDLE;
      beat      <= '0;
      flip      <= 1'b0;
      mem_cnt   <= '0;
      underflow <= 1'b0;
      for (int i = 0; i < GRP_SZ; i++) begin
        glb[i] <= '0; loc[i] <= '0; bnk[0][i] <= '0; bnk[1][i] <= '0;
      end
    end else begin
      underflow <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (save_req) begin
            if (full) begin
              state <= ST_SPILL;
              beat  <= '0;
            end else begin
              flip <= ~flip;
              for (int i = 0; i < GRP_SZ; i++) begin
                loc[i] <= '0; bnk[~flip][i] <= '0;
              end
            end
          end else if (restore_req) begin
            if (!empty) begin
              flip <= ~flip;
              for (int i = 0; i < GRP_SZ; i++) begin
                loc[i] <= '0; bnk[flip][i] <= top_frame[i];
              end
            end else if (mem_cnt != '0) begin
              state <= ST_FILL;
              beat  <= '0;
              flip  <= ~flip;
              for (int i = 0; i < GRP_SZ; i++) loc[i] <= '0;
            end else begin
              underflow <= 1'b1;
            end
          end else if (wr_en && !w_zero) begin
            case (w_grp)
              GRP_GLB: glb[w_off] <= wr_data;
              GRP_LOC: loc[w_off] <= wr_data;
              default: bnk[w_bank][w_off] <= wr_data;
            endcase
          end
        end
        ST_SPILL: begin
          if (spill_ready) begin
            beat <= beat + 1'b1;
            if (last_beat) begin
              state   <= ST_IDLE;
              mem_cnt <= mem_cnt + 1'b1;
              flip    <= ~flip;
              for (int i = 0; i < GRP_SZ; i++) begin
                loc[i] <= '0; bnk[~flip][i] <= '0;
              end
            end
          end
        end
        ST_FILL: begin
          if (fill_valid) begin
            bnk[~flip][beat] <= fill_data;
            beat <= beat + 1'b1;
            if (last_beat) begin
              state   <= ST_IDLE;
              mem_cnt <= mem_cnt - 1'b1;
            end
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/wrf_checker.sv
module wrf_checker #(
  parameter int XLEN = 32
) (
  input logic            clk,
  input logic            rst_n,
  input logic            save_req,
  input logic            restore_req,
  input logic            busy,
  input logic            underflow,
  input logic            spill_valid,
  input logic            spill_ready,
  input logic [XLEN-1:0] spill_data,
  input logic            fill_ready,
  input logic [4:0]      rd_a_idx,
  input logic [XLEN-1:0] rd_a_data
);
  // R11
  spill_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    spill_valid && !spill_ready |=> spill_valid && $stable(spill_data));

  // R9
  underflow_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    underflow |-> $past(restore_req && !save_req && !busy));

  // R10
  busy_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(save_req || restore_req));

  // R2
  zero_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_a_idx == 5'd0 |-> rd_a_data == '0);

  // R7
  stream_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(spill_valid && fill_ready));

  // R8
  fill_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fill_ready |-> busy);
endmodule

bind windowed_regfile wrf_checker #(.XLEN(XLEN)) u_chk (
  .clk(clk), .rst_n(rst_n), .save_req(save_req), .restore_req(restore_req),
  .busy(busy), .underflow(underflow), .spill_valid(spill_valid),
  .spill_ready(spill_ready), .spill_data(spill_data), .fill_ready(fill_ready),
  .rd_a_idx(rd_a_idx), .rd_a_data(rd_a_data)
);

// File: tb/windowed_regfile_test.sv
module windowed_regfile_test;
  localparam int PERIOD = 10;
  localparam int FRAMES = 4;
  typedef logic [7:0][31:0] frm_t;

  logic clk, rst_n;
  logic [4:0] rd_a_idx, rd_b_idx, wr_idx;
  logic [31:0] rd_a_data, rd_b_data, wr_data, spill_data, fill_data;
  logic wr_en, save_req, restore_req, busy, underflow;
  logic spill_valid, spill_ready, fill_valid, fill_ready;

  windowed_regfile #(.XLEN(32), .FRAMES(FRAMES), .MEM_CNT_W(8)) uut (
    .clk(clk), .rst_n(rst_n),
    .rd_a_idx(rd_a_idx), .rd_a_data(rd_a_data),
    .rd_b_idx(rd_b_idx), .rd_b_data(rd_b_data),
    .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
    .save_req(save_req), .restore_req(restore_req),
    .busy(busy), .underflow(underflow),
    .spill_valid(spill_valid), .spill_ready(spill_ready), .spill_data(spill_data),
    .fill_valid(fill_valid), .fill_ready(fill_ready), .fill_data(fill_data)
  );

  initial clk = 1'b0;
  always #(PERIOD/2) clk = ~clk;

  int checks = 0, errors = 0, cyc = 0;
  bit spill_seen;

  // reference model
  logic [31:0] mg [8], ml [8], mi [8], mo [8];
  frm_t mstk [$];
  int mmem = 0, mph = 0, mbeat = 0;
  bit mund = 0;

  // memory agent
  frm_t agq [$];
  frm_t agb;
  int ags = 0, agf = 0;

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] mread(logic [4:0] i);
    if (i == 5'd0) return 32'd0;
    case (i[4:3])
      2'd0: return mg[i[2:0]];
      2'd1: return mo[i[2:0]];
      2'd2: return ml[i[2:0]];
      default: return mi[i[2:0]];
    endcase
  endfunction

  task automatic msave();
    frm_t f;
    for (int j = 0; j < 8; j++) f[j] = mi[j];
    mstk.push_back(f);
    for (int j = 0; j < 8; j++) begin mi[j] = mo[j]; mo[j] = 0; ml[j] = 0; end
  endtask

  task automatic model_update();
    mund = 0;
    if (mph == 0) begin
      if (save_req) begin
        if (mstk.size() == FRAMES) begin mph = 1; mbeat = 0; end
        else msave();
      end else if (restore_req) begin
        if (mstk.size() > 0) begin
          frm_t f;
          f = mstk.pop_back();
          for (int j = 0; j < 8; j++) begin mo[j] = mi[j]; mi[j] = f[j]; ml[j] = 0; end
        end else if (mmem > 0) begin
          mph = 2; mbeat = 0;
          for (int j = 0; j < 8; j++) begin mo[j] = mi[j]; ml[j] = 0; end
        end else mund = 1;
      end else if (wr_en && wr_idx != 0) begin
        case (wr_idx[4:3])
          2'd0: mg[wr_idx[2:0]] = wr_data;
          2'd1: mo[wr_idx[2:0]] = wr_data;
          2'd2: ml[wr_idx[2:0]] = wr_data;
          default: mi[wr_idx[2:0]] = wr_data;
        endcase
      end
    end else if (mph == 1) begin
      if (spill_ready) begin
        mbeat++;
        if (mbeat == 8) begin
          void'(mstk.pop_front());
          mmem++;
          msave();
          mph = 0;
        end
      end
    end else begin
      if (fill_valid) begin
        mi[mbeat] = fill_data;
        mbeat++;
        if (mbeat == 8) begin mmem--; mph = 0; end
      end
    end
  endtask

  task automatic agent();
    spill_ready = (cyc % 3) != 1;
    if (spill_valid && spill_ready) begin
      agb[ags] = spill_data;
      ags++;
      if (ags == 8) begin agq.push_back(agb); ags = 0; end
    end
    fill_valid = ((cyc % 4) != 2) && (agq.size() > 0);
    fill_data  = (agq.size() > 0) ? agq[$][agf] : 32'd0;
    if (fill_valid && fill_ready) begin
      agf++;
      if (agf == 8) begin void'(agq.pop_back()); agf = 0; end
    end
  endtask

  task automatic check_all();
    chk("R10 busy", busy, mph != 0);
    chk("R9 underflow", underflow, mund);
    chk("R7 spill_valid", spill_valid, mph == 1);
    if (mph == 1) chk("R7 R11 spill_data", spill_data, mstk[0][mbeat]);
    chk("R8 fill_ready", fill_ready, mph == 2);
    if (mph == 0) begin
      chk("R1 read a", rd_a_data, mread(rd_a_idx));
      chk("R1 read b", rd_b_data, mread(rd_b_idx));
    end
  endtask

  task automatic step();
    rd_a_idx = 5'(cyc % 32);
    rd_b_idx = 5'((cyc * 7 + 3) % 32);
    agent();
    model_update();
    if (spill_valid) spill_seen = 1;
    @(posedge clk);
    #1;
    cyc++;
    check_all();
  endtask

  task automatic wait_idle();
    for (int k = 0; k < 200 && busy; k++) step();
  endtask

  task automatic wr(logic [4:0] idx, logic [31:0] val);
    wr_en = 1; wr_idx = idx; wr_data = val;
    step();
    wr_en = 0;
  endtask

  task automatic do_save();
    save_req = 1; step(); save_req = 0; wait_idle();
  endtask

  task automatic do_rest();
    restore_req = 1; step(); restore_req = 0; wait_idle();
  endtask

  task automatic rdchk(string tag, logic [4:0] idx, logic [31:0] exp);
    rd_a_idx = idx;
    #1;
    chk(tag, rd_a_data, exp);
  endtask

  initial begin
    #(PERIOD * 150000);
    errors++;
    $display("FAIL R10 watchdog: actual hung expected finished");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    for (int j = 0; j < 8; j++) begin mg[j] = 0; ml[j] = 0; mi[j] = 0; mo[j] = 0; end
    rst_n = 0; wr_en = 0; wr_idx = 0; wr_data = 0; save_req = 0; restore_req = 0;
    rd_a_idx = 5'd24; rd_b_idx = 5'd9; spill_ready = 0; fill_valid = 0; fill_data = 0;
    repeat (3) @(posedge clk);
    #1;
    rst_n = 1;
    chk("reset busy", busy, 0);
    chk("reset spill_valid", spill_valid, 0);
    chk("reset fill_ready", fill_ready, 0);
    chk("reset underflow", underflow, 0);
    chk("reset read", rd_a_data, 0);

    for (int i = 1; i < 32; i++) wr(5'(i), 32'hA000_0000 + i);
    // R2
    wr(5'd0, 32'hDEAD_BEEF);
    rdchk("R2 zero read", 5'd0, 32'd0);
    // R3
    wr_en = 1; wr_idx = 5'd6; wr_data = 32'h0000_1234; rd_a_idx = 5'd6;
    #1 chk("R3 old value same cycle", rd_a_data, 32'hA000_0006);
    step(); wr_en = 0;
    rdchk("R3 new value next cycle", 5'd6, 32'h0000_1234);

    spill_seen = 0;
    do_save();
    rdchk("R4 in0 from out0", 5'd24, 32'hA000_0008);
    rdchk("R4 in1 from out1", 5'd25, 32'hA000_0009);
    rdchk("R4 outs cleared", 5'd8, 32'd0);
    rdchk("R4 locals cleared", 5'd16, 32'd0);
    rdchk("R1 global kept", 5'd5, 32'hA000_0005);

    for (int d = 2; d <= 6; d++) begin
      for (int j = 0; j < 8; j++) wr(5'(8 + j), 32'hB000_0000 + d * 16 + j);
      if (d == 5) begin
        save_req = 1; step(); save_req = 0;
        chk("R7 busy after full save", busy, 1);
        wr_en = 1; wr_idx = 5'd3; wr_data = 32'hFFFF_FFFF; save_req = 1; restore_req = 1;
        step();
        wr_en = 0; save_req = 0; restore_req = 0;
        wait_idle();
      end else do_save();
      if (d == 4) chk("R6 no spill up to depth", spill_seen, 0);
    end
    chk("R7 frames spilled", agq.size(), 2);
    chk("R7 oldest first word", agq[0][0], 32'hA000_0018);
    chk("R7 oldest last word", agq[0][7], 32'hA000_001F);
    chk("R7 second frame first word", agq[1][0], 32'hA000_0008);
    rdchk("R10 write while busy dropped", 5'd3, 32'hA000_0003);

    do_rest();
    rdchk("R5 outs from ins", 5'd8, 32'hB000_0060);
    rdchk("R5 ins popped", 5'd24, 32'hB000_0050);
    rdchk("R5 locals cleared", 5'd16, 32'd0);
    do_rest(); do_rest(); do_rest();
    rdchk("R5 fourth pop", 5'd24, 32'hB000_0020);

    do_rest();
    rdchk("R8 fill word0", 5'd24, 32'hA000_0008);
    rdchk("R8 fill word7", 5'd31, 32'hA000_000F);
    rdchk("R8 outs from ins", 5'd8, 32'hB000_0020);
    do_rest();
    rdchk("R8 second fill", 5'd24, 32'hA000_0018);
    rdchk("R8 outs after second fill", 5'd8, 32'hA000_0008);
    rdchk("R1 global after unwind", 5'd7, 32'hA000_0007);

    restore_req = 1; step(); restore_req = 0;
    chk("R9 underflow pulse", underflow, 1);
    step();
    chk("R9 underflow single cycle", underflow, 0);
    rdchk("R9 ins unchanged", 5'd24, 32'hA000_0018);
    rdchk("R9 outs unchanged", 5'd8, 32'hA000_0008);

    wr_en = 1; wr_idx = 5'd2; wr_data = 32'h0000_0055; save_req = 1; restore_req = 1;
    step();
    wr_en = 0; save_req = 0; restore_req = 0;
    wait_idle();
    rdchk("R10 save wins over restore", 5'd24, 32'hA000_0008);
    rdchk("R10 write dropped with save", 5'd2, 32'hA000_0002);
    step();

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule